// File: doc/BRIEF.md
# Per-Lane Bit Manipulation Unit

This block is a packed-SIMD datapath. It takes a wide operand word made of `N` elements of `EW` bits each, applies one selected bit-manipulation operation to every element at once, and returns the whole vector one clock later. Each element is computed on its own: no result bit of one lane depends on the contents of another lane.

The unit offers six operations. Three are reversals at different granularities: the whole element, the bits inside each byte, and the order of the bytes. Three are counts: leading zeros, trailing zeros and set bits. A count is zero-extended to the full element width. The reversal inside each byte is the bit reflection used by GHASH. The byte-order reversal serves endianness conversion.

A caller presents the operand, a 3-bit opcode and a valid strobe. The result register loads only on a valid cycle and keeps its value in every other cycle.

Top module: `lane_bitops`

## Requirements
- R1: Opcode 0 (full reverse) places bit i of each element at bit EW-1-i of the same element.
- R2: Opcode 1 (bit reverse inside bytes) places bit j of byte b at bit 7-j of byte b, within each element.
- R3: Opcode 2 (byte-order reverse) moves byte k of each element to byte EW/8-1-k and keeps the bit order inside each byte.
- R4: Opcode 3 returns, per element, the count of consecutive zeros from the most significant bit. An all-zero element returns EW.
- R5: Opcode 4 returns, per element, the count of consecutive zeros from the least significant bit. An all-zero element returns EW.
- R6: Opcode 5 returns, per element, the number of bits that are one. Every count result is zero-extended to EW bits.
- R7: Opcodes 6 and 7 produce an all-zero result.
- R8: `out_valid` is `in_valid` delayed by exactly one clock. The result for a valid input appears on `result` in that same cycle.
- R9: Each lane's result depends only on that lane's operand element, even when neighbouring lanes hold very different values.
- R10: While `rst_n` is low, `out_valid` and `result` are zero.
- R11: In a cycle with `in_valid` low, `result` keeps its previous value whatever the operand and opcode are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand and opcode are valid this cycle |
| op | input | 3 | Operation select (0..5; other values give zero) |
| operand | input | N*EW | Packed operand, element l in bits l*EW+EW-1 : l*EW |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| result | output | N*EW | Packed per-element result |

## Verification
The hardest cases to reach are the count boundaries inside a mixed vector. Lanes must sit at zero, at EW, and at values in between in the same word, so that a count that spills into a neighbour or saturates early shows up. The stimulus builds operands lane by lane: an all-zero lane, an all-ones lane, a lane with a single bit at the top, and one with a single bit at the bottom. It runs every opcode on such words next to random operands. Idle cycles with changing operands check that the held result does not move.

// File: rtl/lane_bitops.sv
module lane_bitops #(
  parameter int N  = 4,
  parameter int EW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [2:0]    op,
  input  logic [N*EW-1:0] operand,
  output logic          out_valid,
  output logic [N*EW-1:0] result
);
  localparam int NB = EW / 8;
  localparam int CW = $clog2(EW + 1);

  logic [N*EW-1:0] nxt;

  for (genvar l = 0; l < N; l++) begin : g_lane
    logic [EW-1:0] a, rbit, rinb, rbyte, sel;
    logic [CW-1:0] lz, tz, pc;

    assign a = operand[l*EW +: EW];

    for (genvar i = 0; i < EW; i++) begin : g_bit
      assign rbit[i] = a[EW-1-i];
      assign rinb[i] = a[(i/8)*8 + 7 - (i%8)];
    end

    for (genvar k = 0; k < NB; k++) begin : g_byte
      assign rbyte[k*8 +: 8] = a[(NB-1-k)*8 +: 8];
    end

    always_comb begin
      lz = CW'(EW);
      tz = CW'(EW);
      pc = '0;
      for (int i = 0; i < EW; i++) begin
        if (a[i]) lz = CW'(EW - 1 - i);
        if (a[EW-1-i]) tz = CW'(EW - 1 - i);
        pc = pc + CW'(a[i]);
      end
    end

    always_comb begin
      case (op)
        3'd0:    sel = rbit;
        3'd1:    sel = rinb;
        3'd2:    sel = rbyte;
        3'd3:    sel = EW'(lz);
        3'd4:    sel = EW'(tz);
        3'd5:    sel = EW'(pc);
        default: sel = '0;
      endcase
    end

    assign nxt[l*EW +: EW] = sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= nxt;
    end
  end
endmodule

module lane_bitops_chk #(
  parameter int N  = 4,
  parameter int EW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [2:0]    op,
  input logic [N*EW-1:0] operand,
  input logic          out_valid,
  input logic [N*EW-1:0] result
);
  // R8
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  // R11
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));

  // R7
  bad_op_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op > 3'd5) |=> result == '0);

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && result == '0));

  for (genvar l = 0; l < N; l++) begin : g_chk
    // R1
    reverse_keeps_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op <= 3'd2) |=>
        $countones(result[l*EW +: EW]) == $countones($past(operand[l*EW +: EW])));

    // R6
    popcount_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 3'd5) |=>
        result[l*EW +: EW] == EW'($countones($past(operand[l*EW +: EW]))));

    // R4
    zero_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 3'd3 && operand[l*EW +: EW] == '0) |=>
        result[l*EW +: EW] == EW'(EW));

    // R5
    zero_trail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 3'd4 && operand[l*EW +: EW] == '0) |=>
        result[l*EW +: EW] == EW'(EW));
  end
endmodule

bind lane_bitops lane_bitops_chk #(.N(N), .EW(EW)) u_chk (.*);

// File: tb/sim_lane_bitops.sv
module sim_lane_bitops;
  localparam int PERIOD = 10;
  localparam int N  = 4;
  localparam int EW = 32;
  localparam int W  = N * EW;
  localparam int NB = EW / 8;

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [2:0] op = '0;
  logic [W-1:0] operand = '0;
  logic out_valid;
  logic [W-1:0] result;

  typedef struct { logic [W-1:0] data; logic [2:0] op; } item_t;
  item_t q[$];
  int total = 0, bad = 0;
  logic [W-1:0] last = '0;

  lane_bitops #(.N(N), .EW(EW)) u0 (.*);

  always #(PERIOD/2) clk = ~clk;

  function automatic string tag(input logic [2:0] o);
    case (o)
      3'd0: return "R1"; 3'd1: return "R2"; 3'd2: return "R3";
      3'd3: return "R4"; 3'd4: return "R5"; 3'd5: return "R6";
      default: return "R7";
    endcase
  endfunction

  function automatic logic [W-1:0] model(input logic [2:0] o, input logic [W-1:0] v);
    logic [W-1:0] out = '0;
    for (int l = 0; l < N; l++) begin
      logic [EW-1:0] e = v[l*EW +: EW];
      logic [EW-1:0] r = '0;
      int c = 0;
      case (o)
        3'd0: for (int i = 0; i < EW; i++) r[EW-1-i] = e[i];
        3'd1: for (int b = 0; b < NB; b++) for (int j = 0; j < 8; j++) r[b*8+j] = e[b*8+7-j];
        3'd2: for (int b = 0; b < NB; b++) r[b*8 +: 8] = e[(NB-1-b)*8 +: 8];
        3'd3: begin while (c < EW && !e[EW-1-c]) c++; r = EW'(c); end
        3'd4: begin while (c < EW && !e[c]) c++; r = EW'(c); end
        3'd5: begin for (int i = 0; i < EW; i++) c += int'(e[i]); r = EW'(c); end
        default: r = '0;
      endcase
      out[l*EW +: EW] = r;
    end
    return out;
  endfunction

  task automatic drive(input logic [2:0] o, input logic [W-1:0] v);
    item_t it;
    @(negedge clk);
    in_valid = 1; op = o; operand = v;
    it.data = model(o, v); it.op = o;
    q.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0; op = 3'(i); operand = {N{32'hA5C3_0F71}} ^ W'(i * 977);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (out_valid) begin
        item_t it;
        total++;
        if (q.size() == 0) begin
          bad++;
          $display("FAIL R8 unexpected out_valid actual=1 expected=0");
        end else begin
          it = q.pop_front();
          if (result !== it.data) begin
            bad++;
            $display("FAIL %s op=%0d actual=%h expected=%h", tag(it.op), it.op, result, it.data);
          end
          last = it.data;
        end
      end else if (q.size() == 0 && !in_valid) begin
        // R11 result held while idle
        total++;
        if (result !== last) begin
          bad++;
          $display("FAIL R11 actual=%h expected=%h", result, last);
        end
      end
    end
  end

  initial begin
    #(PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [W-1:0] mix;
    operand = '1; op = 3'd0;
    repeat (3) @(negedge clk);
    // R10 reset state
    total++;
    if (out_valid !== 1'b0 || result !== '0) begin
      bad++;
      $display("FAIL R10 actual=%b/%h expected=0/0", out_valid, result);
    end
    operand = '0;
    rst_n = 1;
    idle(2);
    // R9: lanes with zero, ones, top bit, bottom bit side by side
    mix = {32'h0000_0001, 32'h8000_0000, 32'hFFFF_FFFF, 32'h0000_0000};
    for (int o = 0; o < 8; o++) drive(3'(o), mix);
    for (int o = 0; o < 8; o++) drive(3'(o), {32'h0001_0000, 32'h0000_0000, 32'h00F0_0000, 32'h1234_5678});
    for (int o = 0; o < 6; o++) drive(3'(o), '0);
    for (int o = 0; o < 6; o++) drive(3'(o), '1);
    idle(4);
    for (int k = 0; k < 60; k++) begin
      drive(3'($urandom_range(0, 7)), {$urandom, $urandom, $urandom, $urandom});
      if (k % 7 == 0) idle(2);
    end
    // R8: back-to-back with a gap
    drive(3'd3, {32'h0000_8000, 32'h0100_0000, 32'h0000_0002, 32'h4000_0000});
    idle(1);
    drive(3'd4, {32'h0000_8000, 32'h0100_0000, 32'h0000_0002, 32'h4000_0000});
    idle(5);
    if (q.size() != 0) begin
      bad++; total++;
      $display("FAIL R8 pending results actual=%0d expected=0", q.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule